// File: doc/BRIEF.md
# Dual-Rate Descriptor Poll Timer

This block decides when a DMA engine should re-read the descriptor it is currently parked on. It produces two single-cycle strobes, one for the transmit path and one for the receive path. A divide-by-three prescaler drives a down-counter. The counter reloads from one of two programmable interval values. The normal interval is used while traffic flows. The chain interval is used while the descriptor logic reports that a frame has been partly fetched and the next descriptor is still held by software, which lets that case be polled at a faster rate.

Besides the timed polls, a software demand strobe and the end of a transmit operation each raise a transmit poll at once and restart the count. Disable inputs mute timed polls per path or during chain mode. A receive path that is quiet and holds enough buffers is not polled. A busy input from the consumer holds back any poll until the consumer is free. A zero interval counts as the full counter range.

Top module: `desc_poll_timer`

## Requirements
- R1: With no other event, timed polls are spaced exactly 3*N clock cycles apart, where N is the selected interval. The first timed poll after a count restart comes 3*N cycles after the restarting edge.
- R2: An interval value of zero behaves as 2^W counts, where W is the interval width, giving 3*2^W cycles between polls.
- R3: While chain_req_i is high the chain interval is used, and otherwise the normal interval is used. Any change of chain_req_i restarts the count with the newly selected interval.
- R4: A demand_i cycle raises tx_poll_o in the next cycle in either mode, even when transmit polling is disabled, and restarts the count.
- R5: While chain_req_i and chain_dis_i are both high, no timed poll appears on either output.
- R6: tx_dis_i blocks timed transmit polls but leaves timed receive polls unchanged.
- R7: A timed receive poll is dropped when rx_idle_i and rx_own2_i are both high.
- R8: A tx_end_i cycle with next_owned_i low raises tx_poll_o in the next cycle and restarts the count. With next_owned_i high, tx_end_i has no effect.
- R9: A new interval value written mid-count does not cut short the running period. It is loaded at the next period boundary.
- R10: No poll is emitted in the cycle after busy_i is high. A poll raised meanwhile is held and emitted in the cycle after busy_i is first seen low. Each poll is a single-cycle pulse.
- R11: During reset both outputs are low. The first count starts on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| norm_intv_i | input | W | Normal poll interval (0 means 2^W) |
| chain_intv_i | input | W | Chain-mode poll interval (0 means 2^W) |
| chain_req_i | input | 1 | Frame stalled mid-chain; select chain interval |
| demand_i | input | 1 | Software transmit demand strobe |
| tx_dis_i | input | 1 | Disable timed transmit polls |
| chain_dis_i | input | 1 | Disable timed polls while in chain mode |
| next_owned_i | input | 1 | Next descriptor already known to be owned |
| tx_end_i | input | 1 | A transmit operation has ended |
| rx_idle_i | input | 1 | No network activity on the receive side |
| rx_own2_i | input | 1 | At least two receive descriptors held by hardware |
| busy_i | input | 1 | Consumer busy; hold back new polls |
| tx_poll_o | output | 1 | Transmit poll pulse |
| rx_poll_o | output | 1 | Receive poll pulse |

## Verification
The hardest case to reach is a full-range zero interval that expires while busy_i is high and a mode change or demand is also arriving. Expiry, hold-back and restart then meet in the same few cycles. To reach it, the bench builds the block with a narrow interval width, so a zero interval runs its whole count in under a thousand cycles. A long randomized phase then toggles busy, demand, transmit-end and mode changes over many periods while a behavioural cycle-count model tracks every edge.

// File: rtl/poll_pkg.sv
package poll_pkg;
  localparam int PATHS   = 2;
  localparam int PATH_TX = 0;
  localparam int PATH_RX = 1;
  typedef logic [PATHS-1:0] path_vec_t;
endpackage

// File: rtl/pt_prescale.sv
module pt_prescale #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q, pre_d;

  assign tick_o = (pre_q == PW'(DIV - 1));

  always_comb begin
    if (clr_i || tick_o) pre_d = '0;
    else                 pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/pt_interval.sv
module pt_interval #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         chain_i,
  input  logic [W-1:0] norm_intv_i,
  input  logic [W-1:0] chain_intv_i,
  input  logic         kick_i,
  output logic         restart_o,
  output logic         expire_o
);
  localparam int CW = W + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mode_q;
  logic [W-1:0]  sel;
  logic [CW-1:0] load;

  assign sel  = chain_i ? chain_intv_i : norm_intv_i;
  assign load = (sel == '0) ? (CW'(1) << W) : {1'b0, sel};

  // cnt_q of zero only occurs straight after reset: forces the first load
  assign restart_o = (cnt_q == '0) || (chain_i != mode_q) || kick_i;
  assign expire_o  = !restart_o && tick_i && (cnt_q == CW'(1));

  always_comb begin
    if (restart_o || expire_o) cnt_d = load;
    else if (tick_i)           cnt_d = cnt_q - CW'(1);
    else                       cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= chain_i;
    end
  end
endmodule

// File: rtl/pt_gate.sv
module pt_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  input  logic busy_i,
  output logic poll_o
);
  logic pend_q, pend_d, poll_q, poll_d, want;

  assign want   = pend_q || ev_i;
  assign poll_d = want && !busy_i;
  assign pend_d = want && busy_i;
  assign poll_o = poll_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      poll_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      poll_q <= poll_d;
    end
  end
endmodule

// File: rtl/desc_poll_timer.sv
module desc_poll_timer
  import poll_pkg::*;
#(
  parameter int W   = 16,
  parameter int DIV = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] norm_intv_i,
  input  logic [W-1:0] chain_intv_i,
  input  logic         chain_req_i,
  input  logic         demand_i,
  input  logic         tx_dis_i,
  input  logic         chain_dis_i,
  input  logic         next_owned_i,
  input  logic         tx_end_i,
  input  logic         rx_idle_i,
  input  logic         rx_own2_i,
  input  logic         busy_i,
  output logic         tx_poll_o,
  output logic         rx_poll_o
);
  logic      tick_w, restart_w, expire_w, kick_w, timed_ok;
  path_vec_t ev, poll;

  assign kick_w   = demand_i || (tx_end_i && !next_owned_i);
  assign timed_ok = !(chain_req_i && chain_dis_i);

  pt_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(restart_w), .tick_o(tick_w)
  );

  pt_interval #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .chain_i(chain_req_i),
    .norm_intv_i(norm_intv_i), .chain_intv_i(chain_intv_i),
    .kick_i(kick_w), .restart_o(restart_w), .expire_o(expire_w)
  );

  assign ev[PATH_TX] = (expire_w && timed_ok && !tx_dis_i) || kick_w;
  assign ev[PATH_RX] = expire_w && timed_ok && !(rx_idle_i && rx_own2_i);

  for (genvar p = 0; p < PATHS; p++) begin : g_path
    pt_gate u_gate (
      .clk(clk), .rst_n(rst_n), .ev_i(ev[p]), .busy_i(busy_i), .poll_o(poll[p])
    );
  end

  assign tx_poll_o = poll[PATH_TX];
  assign rx_poll_o = poll[PATH_RX];
endmodule

// File: rtl/desc_poll_timer_chk.sv
module desc_poll_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic demand_i,
  input logic tx_end_i,
  input logic next_owned_i,
  input logic busy_i,
  input logic tick_w,
  input logic expire_w,
  input logic tx_poll_o,
  input logic rx_poll_o
);
  // R4
  demand_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    demand_i && !busy_i |=> tx_poll_o);

  // R8
  end_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end_i && !next_owned_i && !busy_i |=> tx_poll_o);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !tx_poll_o && !rx_poll_o);

  // R1
  expire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |-> tick_w);

  // R11
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (!tx_poll_o && !rx_poll_o);
  end
endmodule

bind desc_poll_timer desc_poll_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .demand_i(demand_i), .tx_end_i(tx_end_i),
  .next_owned_i(next_owned_i), .busy_i(busy_i), .tick_w(tick_w),
  .expire_w(expire_w), .tx_poll_o(tx_poll_o), .rx_poll_o(rx_poll_o)
);

// File: tb/sim_desc_poll_timer.sv
module sim_desc_poll_timer;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] norm_intv, chain_intv;
  logic chain_req, demand, tx_dis, chain_dis, next_owned, tx_end;
  logic rx_idle, rx_own2, busy;
  logic tx_poll, rx_poll;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R11";

  always #10 clk = ~clk;

  desc_poll_timer #(.W(W), .DIV(3)) u0 (
    .clk(clk), .rst_n(rst_n), .norm_intv_i(norm_intv), .chain_intv_i(chain_intv),
    .chain_req_i(chain_req), .demand_i(demand), .tx_dis_i(tx_dis),
    .chain_dis_i(chain_dis), .next_owned_i(next_owned), .tx_end_i(tx_end),
    .rx_idle_i(rx_idle), .rx_own2_i(rx_own2), .busy_i(busy),
    .tx_poll_o(tx_poll), .rx_poll_o(rx_poll)
  );

  // behavioural model: counts remaining clock cycles to the next expiry
  int left;
  bit mode, tpend, rpend, etx, erx;

  function automatic int span(input logic [W-1:0] v);
    return 3 * ((v == 0) ? (1 << W) : int'(v));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left = 0; mode = 0; tpend = 0; rpend = 0; etx = 0; erx = 0;
    end else begin
      bit kick, rst_cnt, exp_now, ok, tev, rev;
      int nspan;
      nspan   = span(chain_req ? chain_intv : norm_intv);
      kick    = demand || (tx_end && !next_owned);
      rst_cnt = (left == 0) || (chain_req != mode) || kick;
      exp_now = 0;
      if (rst_cnt) left = nspan;
      else if (left == 1) begin exp_now = 1; left = nspan; end
      else left = left - 1;
      mode = chain_req;
      ok  = !(chain_req && chain_dis);
      tev = (exp_now && ok && !tx_dis) || kick;
      rev = exp_now && ok && !(rx_idle && rx_own2);
      tpend = tpend || tev;
      rpend = rpend || rev;
      etx = tpend && !busy;
      erx = rpend && !busy;
      if (!busy) begin tpend = 0; rpend = 0; end
    end
  end

  always @(negedge clk) begin
    cyc++;
    checks += 2;
    if (tx_poll !== etx) begin
      errors++;
      $display("FAIL %s tx_poll actual=%0b expected=%0b cycle=%0d", cur_req, tx_poll, etx, cyc);
    end
    if (rx_poll !== erx) begin
      errors++;
      $display("FAIL %s rx_poll actual=%0b expected=%0b cycle=%0d", cur_req, rx_poll, erx, cyc);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_demand;
    demand = 1'b1; @(negedge clk); demand = 1'b0;
  endtask

  task automatic strobe_end(input logic own);
    tx_end = 1'b1; next_owned = own; @(negedge clk);
    tx_end = 1'b0; next_owned = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    norm_intv = 8'd5; chain_intv = 8'd3;
    chain_req = 0; demand = 0; tx_dis = 0; chain_dis = 0;
    next_owned = 0; tx_end = 0; rx_idle = 0; rx_own2 = 0; busy = 0;
    run(3);
    rst_n = 1'b1;
    cur_req = "R11"; run(2);
    cur_req = "R1";  run(60);
    cur_req = "R9";  run(4); norm_intv = 8'd7; run(60);
    cur_req = "R2";  norm_intv = 8'd0; run(1600);
    norm_intv = 8'd4;
    cur_req = "R3";  run(20); chain_req = 1; chain_intv = 8'd2; run(40);
    cur_req = "R5";  chain_dis = 1; run(40); chain_req = 0; run(30); chain_dis = 0;
    cur_req = "R4";  run(5); strobe_demand(); run(7); strobe_demand(); strobe_demand(); run(20);
    chain_req = 1; run(3); strobe_demand(); run(15); chain_req = 0;
    cur_req = "R6";  tx_dis = 1; run(40); strobe_demand(); run(20); tx_dis = 0;
    cur_req = "R7";  rx_idle = 1; run(30); rx_own2 = 1; run(40); rx_idle = 0; run(30); rx_own2 = 0;
    cur_req = "R8";  run(3); strobe_end(1'b0); run(9); strobe_end(1'b1); run(20);
    cur_req = "R10"; run(5); busy = 1; strobe_demand(); run(25); busy = 0; run(20);
    busy = 1; run(12); busy = 0; run(20);
    cur_req = "R3 R4 R8 R10 mixed";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      demand = ($urandom % 23) == 0;
      tx_end = ($urandom % 19) == 0;
      next_owned = $urandom % 2;
      busy = ($urandom % 5) == 0;
      rx_idle = $urandom % 2;
      rx_own2 = $urandom % 2;
      if (($urandom % 40) == 0) chain_req = ~chain_req;
      if (($urandom % 60) == 0) chain_dis = ~chain_dis;
      if (($urandom % 60) == 0) tx_dis = ~tx_dis;
      if (($urandom % 50) == 0) norm_intv = W'($urandom % 7);
      if (($urandom % 50) == 0) chain_intv = W'($urandom % 4);
    end
    demand = 0; tx_end = 0; busy = 0;
    run(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule